// File: doc/BRIEF.md
# Interrupt Aggregation Controller

This block gathers 32 interrupt request lines into a single wired interrupt output. The output can drive a parent interrupt controller, or one input line of another instance of the same block, so that instances can be cascaded. Each request line is first brought into the block clock domain by a two-flop synchroniser. A detector then turns it into a cause event. One control bit picks the detection rule for all lines together: level-high or rising-edge, never a mix of the two.

Software uses a small word-wide register bus with separate write and read strobes, a byte address, write data, read data and a ready flag. Through this bus it reads the latched causes, acknowledges them, masks individual lines and sets the trigger sensitivity. A cause is acknowledged by writing a zero to its bit position. A written one leaves that bit alone, so one line can be cleared without disturbing the others. The output is high while any latched cause has its mask bit clear. A second control bit gates a message-signalled path that is outside this block. It is stored and read back, and it does not change the wired output.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the cause register reads 0x00000000, the mask register reads 0xFFFFFFFF, the control register reads 0x00000000, irq_out is low and bus_ready is low. Each input passes two synchroniser flops and then one cause flop, so a change on irq_in that is driven before a clock edge shows in the cause register three rising edges later.
- R2: Registers sit at byte offsets 0x00 (cause), 0x10 (mask) and 0x28 (control). A bus_wr or bus_rd request held for one cycle is answered by bus_ready high for exactly the following cycle. bus_rdata in that cycle holds the register value as it was in the request cycle.
- R3: Level mode (control bit 3 = 0): a cause bit is set in every cycle in which its synchronised input is high. A bit that software clears while the input is still high therefore reads back as set.
- R4: Edge mode (control bit 3 = 1): a cause bit is set only on a 0-to-1 transition of its synchronised input. An input held high does not set its cause again once that cause has been cleared.
- R5: In a write to the cause register, each data bit of 0 clears the matching cause bit and each data bit of 1 leaves it unchanged.
- R6: When a detected event and a software clear hit the same cause bit in the same cycle, the bit ends up set.
- R7: A mask bit of 1 disables its line and a mask bit of 0 enables it. irq_out is high exactly when some cause bit is 1 while its mask bit is 0. With the mask at all ones, irq_out stays low.
- R8: Control bit 5 is stored and read back and has no effect on irq_out. Control bits other than 3 and 5 ignore writes and read as 0.
- R9: Reads of offsets other than 0x00, 0x10 and 0x28, including offsets that are not word-aligned, return 0. Writes to such offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Asynchronous interrupt request lines, active high |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high after a read |
| bus_ready | output | 1 | Access completion flag, one cycle after the strobe |
| irq_out | output | 1 | Combined wired interrupt output, active high |

## Verification
A corrupted cause bit shows up at the ports in two places. It changes irq_out in the same cycle, provided its mask bit is clear. It also appears in the next read of offset 0x00, one cycle after that read is requested. A wrong trigger-mode state does not show at once. It shows only when a held-high input either fails to come back after an acknowledge or comes back when it should not, three edges after the input changes. The most delicate corner is the cycle in which an acknowledge and a new edge meet, which the bench hits exactly by counting the synchroniser delay. The other corner is the aliasing of unaligned or unmapped offsets onto real registers, which a later read of the real register exposes.

// File: rtl/irqagg_pkg.sv
// Package: shared constants and decode helper for the interrupt aggregator.
// Assumes byte addressing with word-aligned registers; offsets are fixed by
// software convention and therefore kept here rather than as parameters.
package irqagg_pkg;

    localparam int unsigned OFS_CAUSE    = 32'h00;
    localparam int unsigned OFS_MASK     = 32'h10;
    localparam int unsigned OFS_CTRL     = 32'h28;
    localparam int unsigned CTRL_EDGE_BIT = 3;
    localparam int unsigned CTRL_MSG_BIT  = 5;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_CAUSE = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_CTRL  = 2'd3
    } reg_sel_e;

    // Map a zero-extended byte address to a register select.
    function automatic reg_sel_e decode_offset(input logic [31:0] byte_addr);
        reg_sel_e sel;
        case (byte_addr)
            OFS_CAUSE: sel = SEL_CAUSE;
            OFS_MASK:  sel = SEL_MASK;
            OFS_CTRL:  sel = SEL_CTRL;
            default:   sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/irqagg_sync.sv
// Module: multi-stage synchroniser for a bus of independent request lines.
// Assumes each line is a slow level that may be sampled in any cycle; no
// bus coherence between lines is implied. STAGES must be at least 1.
module irqagg_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    // First stage samples the asynchronous lines.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= async_in;
    end

    genvar gs;
    generate
        for (gs = 1; gs < STAGES; gs++) begin : g_stage
            // Each further stage re-times the previous one.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[gs] <= '0;
                else        chain_q[gs] <= chain_q[gs-1];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irqagg_detect.sv
// Module: per-line event detector. In level mode every high line requests a
// cause set; in edge mode only a line that was low last cycle and is high now.
// Assumes inputs are already synchronous to clk.
module irqagg_detect #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sync_in,
    input  logic             edge_mode,
    output logic [WIDTH-1:0] set_vec
);

    logic [WIDTH-1:0] prev_q;

    // Remember last cycle's synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_in;
    end

    genvar gl;
    generate
        for (gl = 0; gl < WIDTH; gl++) begin : g_line
            // Choose the set request for one line from the global mode.
            always_comb begin
                if (edge_mode) set_vec[gl] = sync_in[gl] & ~prev_q[gl];
                else           set_vec[gl] = sync_in[gl];
            end
        end
    endgenerate

endmodule

// File: rtl/irqagg_regs.sv
// Module: register file and bus responder. Holds cause, mask and the two
// implemented control bits. A cause write clears only bits written as zero;
// a set request in the same cycle overrides the clear. One access per strobe,
// answered with ready one cycle later; a read returns the pre-access value.
module irqagg_regs
    import irqagg_pkg::*;
#(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              bus_ready,
    input  logic [WIDTH-1:0]  set_vec,
    output logic [WIDTH-1:0]  cause_q,
    output logic [WIDTH-1:0]  mask_q,
    output logic              edge_mode,
    output logic              msg_gate
);

    reg_sel_e         sel;
    logic [WIDTH-1:0] keep_vec;
    logic [WIDTH-1:0] cause_d;
    logic [WIDTH-1:0] ctrl_view;
    logic [WIDTH-1:0] rd_mux;
    logic             edge_q;
    logic             msg_q;
    logic [WIDTH-1:0] rdata_q;
    logic             ready_q;

    // Decode the byte address into a register select.
    always_comb sel = decode_offset(32'(bus_addr));

    // Bits kept by a cause write: ones keep, zeros clear.
    always_comb begin
        if (bus_wr && sel == SEL_CAUSE) keep_vec = bus_wdata;
        else                            keep_vec = '1;
    end

    // Next cause: surviving bits plus new events (set wins).
    always_comb cause_d = (cause_q & keep_vec) | set_vec;

    // Latch causes every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    // Mask register, all lines disabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                         mask_q <= '1;
        else if (bus_wr && sel == SEL_MASK) mask_q <= bus_wdata;
    end

    // Control bits: trigger mode and message-path gate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= 1'b0;
            msg_q  <= 1'b0;
        end else if (bus_wr && sel == SEL_CTRL) begin
            edge_q <= bus_wdata[CTRL_EDGE_BIT];
            msg_q  <= bus_wdata[CTRL_MSG_BIT];
        end
    end

    // Control register as seen by software; unimplemented bits are zero.
    always_comb begin
        ctrl_view                = '0;
        ctrl_view[CTRL_EDGE_BIT] = edge_q;
        ctrl_view[CTRL_MSG_BIT]  = msg_q;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        case (sel)
            SEL_CAUSE: rd_mux = cause_q;
            SEL_MASK:  rd_mux = mask_q;
            SEL_CTRL:  rd_mux = ctrl_view;
            default:   rd_mux = '0;
        endcase
    end

    // Register read data and completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            ready_q <= 1'b0;
        end else begin
            ready_q <= bus_wr | bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_ready = ready_q;
    assign edge_mode = edge_q;
    assign msg_gate  = msg_q;

endmodule

// File: rtl/irq_aggregator.sv
// Module: top of the interrupt aggregator. Synchronises the request lines,
// detects events under one global trigger mode, latches them as causes and
// ORs the unmasked causes into one wired output. Assumes a single clock and
// a bus master that issues at most one access per cycle.
module irq_aggregator #(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 bus_ready,
    output logic                 irq_out
);

    logic [NUM_LINES-1:0] sync_vec;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] cause_q;
    logic [NUM_LINES-1:0] mask_q;
    logic                 edge_mode;
    logic                 msg_gate;
    logic                 unused_gate;

    irqagg_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_in),
        .sync_out (sync_vec)
    );

    irqagg_detect #(.WIDTH(NUM_LINES)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_in   (sync_vec),
        .edge_mode (edge_mode),
        .set_vec   (set_vec)
    );

    irqagg_regs #(.WIDTH(NUM_LINES), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .set_vec   (set_vec),
        .cause_q   (cause_q),
        .mask_q    (mask_q),
        .edge_mode (edge_mode),
        .msg_gate  (msg_gate)
    );

    // The gate bit serves a message path outside this block only.
    assign unused_gate = msg_gate;

    // Combine unmasked causes into the wired output.
    always_comb irq_out = |(cause_q & ~mask_q);

endmodule

// File: rtl/irqagg_checker.sv
// Module: property checker for the interrupt aggregator, attached by bind.
// Keeps its own copy of the previous synchronised level so edge checks do
// not reuse the detector's flop.
module irqagg_checker #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned ADDR_W    = 6
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic                 bus_rd,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [NUM_LINES-1:0] bus_rdata,
    input logic                 bus_ready,
    input logic                 irq_out,
    input logic [NUM_LINES-1:0] sync_vec,
    input logic [NUM_LINES-1:0] set_vec,
    input logic [NUM_LINES-1:0] cause_q,
    input logic [NUM_LINES-1:0] mask_q,
    input logic                 edge_mode
);

    logic [NUM_LINES-1:0] chk_prev_q;
    logic                 unmapped;

    // Shadow of last cycle's synchronised inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_prev_q <= '0;
        else        chk_prev_q <= sync_vec;
    end

    // Independent address classification.
    always_comb unmapped = !(32'(bus_addr) == 32'h00 || 32'(bus_addr) == 32'h10 ||
                             32'(bus_addr) == 32'h28);

    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr || bus_rd) |=> bus_ready);                                   // R2
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr || bus_rd) |=> !bus_ready);                                 // R2
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && |sync_vec) |=> ((cause_q & $past(sync_vec)) == $past(sync_vec))); // R3
    AST_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode |=> ((cause_q & ~$past(cause_q) & ~($past(sync_vec) & ~$past(chk_prev_q))) == '0)); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((cause_q & $past(set_vec)) == $past(set_vec)));     // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_q) |-> !irq_out);                                             // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q == '0) |-> !irq_out);                                       // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == '0));                         // R9

endmodule

bind irq_aggregator irqagg_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .irq_out   (irq_out),
    .sync_vec  (sync_vec),
    .set_vec   (set_vec),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .edge_mode (edge_mode)
);

// File: tb/sim_irq_aggregator.sv
// Bench: scoreboard style. Bus tasks push one expected item per access; a
// monitor pops an item on every bus_ready and compares read data.
module sim_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    bit          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .irq_out(irq_out)
    );

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        kind_q.push_back(1'b0); exp_q.push_back('0); tag_q.push_back("R2");
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic [31:0] e, input string tag);
        bus_rd = 1'b1; bus_addr = a;
        kind_q.push_back(1'b1); exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic check_out(input logic e, input string tag);
        n_checks++;
        if (irq_out !== e) begin
            n_fail++;
            $display("FAIL %s irq_out actual=%0b expected=%0b", tag, irq_out, e);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop and compare on each completed access.
    always @(negedge clk) begin
        if (rst_n && bus_ready) begin
            if (kind_q.size() == 0) begin
                n_checks++; n_fail++;
                $display("FAIL R2 unexpected ready actual=1 expected=0");
            end else begin
                bit k; logic [31:0] e; string t;
                k = kind_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
                if (k) begin
                    n_checks++;
                    if (bus_rdata !== e) begin
                        n_fail++;
                        $display("FAIL %s rdata actual=%08h expected=%08h", t, bus_rdata, e);
                    end
                end
            end
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_out(1'b0, "R1");
        n_checks++;
        if (bus_ready !== 1'b0) begin
            n_fail++; $display("FAIL R1 bus_ready actual=%0b expected=0", bus_ready);
        end
        bus_read(6'h00, 32'h0000_0000, "R1 cause reset");
        bus_read(6'h10, 32'hFFFF_FFFF, "R1 mask reset");
        bus_read(6'h28, 32'h0000_0000, "R1 ctrl reset");

        // R3 level capture, masked at first (R7)
        irq_in = 32'h0000_0005;
        wait_cyc(3);
        bus_read(6'h00, 32'h0000_0005, "R1 R3 level latency");
        check_out(1'b0, "R7 all masked");
        bus_write(6'h10, 32'hFFFF_FFFE);
        check_out(1'b1, "R7 unmask line0");
        bus_write(6'h00, 32'hFFFF_FFFE);
        bus_read(6'h00, 32'h0000_0005, "R3 clear while high re-sets");
        irq_in = '0;
        wait_cyc(3);
        bus_write(6'h00, 32'h0000_0000);
        bus_read(6'h00, 32'h0000_0000, "R5 full clear");
        check_out(1'b0, "R7 no cause");

        // R5 partial clear
        irq_in = 32'h0000_0003;
        wait_cyc(3);
        irq_in = '0;
        wait_cyc(3);
        bus_write(6'h00, 32'hFFFF_FFFE);
        bus_read(6'h00, 32'h0000_0002, "R5 ones keep bits");
        bus_write(6'h00, 32'h0000_0000);

        // R4 edge mode
        irq_in = 32'h0000_0010;
        wait_cyc(3);
        bus_write(6'h28, 32'h0000_0008);
        bus_write(6'h00, 32'h0000_0000);
        wait_cyc(3);
        bus_read(6'h00, 32'h0000_0000, "R4 held high no set");
        irq_in = 32'h0000_0030;
        wait_cyc(3);
        bus_read(6'h00, 32'h0000_0020, "R4 rising edge sets");
        bus_write(6'h00, 32'h0000_0000);
        wait_cyc(3);
        bus_read(6'h00, 32'h0000_0000, "R4 no re-set after clear");
        bus_write(6'h10, 32'hFFFF_FFDF);
        check_out(1'b0, "R7 unmasked but no cause");
        irq_in = '0;
        wait_cyc(3);
        irq_in = 32'h0000_0020;
        wait_cyc(3);
        check_out(1'b1, "R4 R7 second edge drives out");
        bus_write(6'h00, 32'h0000_0000);

        // R6 set wins over a clear in the same cycle
        irq_in = 32'h0000_0060;
        wait_cyc(2);
        bus_write(6'h00, 32'h0000_0000);
        bus_read(6'h00, 32'h0000_0040, "R6 edge beats clear");

        // R8 control bit 5
        bus_write(6'h10, 32'hFFFF_FFBF);
        check_out(1'b1, "R7 line6 unmasked");
        bus_write(6'h28, 32'hFFFF_FFFF);
        check_out(1'b1, "R8 gate bit no effect");
        bus_read(6'h28, 32'h0000_0028, "R8 ctrl readback");
        bus_write(6'h28, 32'h0000_0008);
        check_out(1'b1, "R8 gate cleared no effect");
        bus_read(6'h28, 32'h0000_0008, "R8 ctrl gate cleared");

        // R9 unmapped and misaligned accesses
        bus_write(6'h04, 32'hDEAD_BEEF);
        bus_read(6'h04, 32'h0000_0000, "R9 unmapped reads zero");
        bus_read(6'h11, 32'h0000_0000, "R9 misaligned reads zero");
        bus_write(6'h12, 32'h0000_0000);
        bus_write(6'h01, 32'h0000_0000);
        bus_read(6'h10, 32'hFFFF_FFBF, "R9 mask untouched");
        bus_read(6'h00, 32'h0000_0040, "R9 cause untouched");
        check_out(1'b1, "R9 out unchanged");

        // R7 masking everything quiets the output
        bus_write(6'h10, 32'hFFFF_FFFF);
        check_out(1'b0, "R7 mask all");
        bus_write(6'h00, 32'h0000_0000);
        bus_read(6'h00, 32'h0000_0000, "R4 held high stays clear");

        wait_cyc(3);
        n_checks++;
        if (kind_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 pending accesses actual=%0d expected=0", kind_q.size());
        end
        finish_run();
    end

endmodule